// File: doc/BRIEF.md
# MAC Pause Flow-Control Unit

This unit sits beside the transmit and receive paths of a 10 Gb/s Ethernet MAC and handles IEEE 802.3x flow control. The frame parser, which is outside this block, classifies each received control frame. It then presents a one-cycle descriptor saying whether the frame is a pause frame or some other command frame, together with the pause quanta the frame carries. From three configuration inputs the unit decides whether the frame stops the transmitter, goes up to the client, or is discarded. It also runs the countdown that keeps the transmitter held off.

One quantum is 512 bit-times. On a 64-bit datapath at 10 Gb/s that is 8 clock cycles, and this count is a parameter. The hold is applied only between frames, so a frame already in progress finishes first. A new pause frame replaces whatever count remains. On the transmit side, a trigger pulse raises a pause-frame request. The request carries the quanta captured from the configuration input, stays up until the transmitter acknowledges it, and blocks the start of the next data frame.

Top module: `pause_flow_ctl`

## Requirements
- R1: After reset, `tx_hold`, `pause_req`, `rx_forward` and `rx_drop` are 0, `tx_data_ok` is 1 and `pause_quanta` is 0xF000.
- R2: A pause descriptor received with `cfg_ignore`=0 while `tx_in_frame`=0 raises `tx_hold` one cycle after `ctl_valid`. `tx_hold` then stays high for exactly quanta×8 cycles.
- R3: A pause descriptor received with `cfg_ignore`=1 leaves `tx_hold` low.
- R4: For a pause descriptor, `rx_forward` pulses one cycle after `ctl_valid` when `cfg_forward`=1 and `rx_drop` pulses when `cfg_forward`=0. The two outputs are never high together.
- R5: A non-pause command descriptor (`ctl_is_cmd`=1, `ctl_is_pause`=0) is forwarded when `cfg_cmd_all`=1 and dropped when `cfg_cmd_all`=0. When both flags are set, the pause rules apply.
- R6: A pause frame arriving while a hold is active reloads the countdown. The hold then ends new-quanta×8 cycles after the second descriptor.
- R7: A pause descriptor carrying quanta 0 (with `cfg_ignore`=0) drops `tx_hold` on the next cycle.
- R8: While `tx_in_frame`=1, `tx_hold` does not rise. It rises on the cycle after `tx_in_frame` falls, provided the countdown has not expired.
- R9: A `pause_trig` pulse raises `pause_req` on the next cycle and captures `cfg_tx_quanta` into `pause_quanta`. Both then stay unchanged until `pause_ack`, which clears `pause_req` on the next cycle.
- R10: `tx_data_ok` is 0 whenever `pause_req` or `tx_hold` is 1, so a pending pause frame goes out before the next data frame.
- R11: A descriptor with neither flag set produces neither `rx_forward` nor `rx_drop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ignore | input | 1 | Disregard the quanta of received pause frames |
| cfg_forward | input | 1 | Pass pause frames to the client instead of consuming them |
| cfg_cmd_all | input | 1 | Accept all command frames, not only pause frames |
| cfg_tx_quanta | input | 16 | Quanta for transmitted pause frames |
| ctl_valid | input | 1 | Control-frame descriptor valid (one cycle) |
| ctl_is_pause | input | 1 | Descriptor is a pause frame |
| ctl_is_cmd | input | 1 | Descriptor is another command frame |
| ctl_quanta | input | 16 | Quanta carried by the received pause frame |
| tx_in_frame | input | 1 | Transmitter is in the middle of a frame |
| tx_hold | output | 1 | Transmitter must not start a data frame |
| tx_data_ok | output | 1 | A data frame may start |
| rx_forward | output | 1 | Pass the control frame to the client |
| rx_drop | output | 1 | Discard the control frame |
| pause_trig | input | 1 | Request transmission of a pause frame |
| pause_req | output | 1 | Pause frame pending |
| pause_quanta | output | 16 | Quanta for the pending pause frame |
| pause_ack | input | 1 | Transmitter has taken the pause frame |

## Verification
The embedded properties check on every cycle that forward and drop are exclusive, and that the hold rises only across a frame boundary. They also check that ignored or zero-quanta pause frames leave the hold low, that rejected command frames are dropped, and that the request stays up until it is acknowledged. The bench scenarios are needed for the exact hold length in cycles and for the reload of a running countdown. They also cover the capture and stability of the transmit quanta and the full matrix of ignore, forward and accept-all settings.

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl #(
  parameter int QW            = 16,
  parameter int CYC_PER_Q     = 8,
  parameter int TX_QUANTA_RST = 'hF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ignore,
  input  logic          cfg_forward,
  input  logic          cfg_cmd_all,
  input  logic [QW-1:0] cfg_tx_quanta,
  input  logic          ctl_valid,
  input  logic          ctl_is_pause,
  input  logic          ctl_is_cmd,
  input  logic [QW-1:0] ctl_quanta,
  input  logic          tx_in_frame,
  output logic          tx_hold,
  output logic          tx_data_ok,
  output logic          rx_forward,
  output logic          rx_drop,
  input  logic          pause_trig,
  output logic          pause_req,
  output logic [QW-1:0] pause_quanta,
  input  logic          pause_ack
);
  localparam int CW = QW + $clog2(CYC_PER_Q);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_d, fwd_d, drop_d, take;

  assign take = ctl_valid && ctl_is_pause && !cfg_ignore;

  always_comb begin
    if (take)
      cnt_d = CW'(ctl_quanta) * CW'(CYC_PER_Q);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
    else
      cnt_d = cnt_q;
  end

  assign hold_d = (cnt_d != '0) && (tx_hold || !tx_in_frame);
  assign fwd_d  = ctl_valid && (ctl_is_pause ? cfg_forward : (ctl_is_cmd && cfg_cmd_all));
  assign drop_d = ctl_valid && (ctl_is_pause ? !cfg_forward : (ctl_is_cmd && !cfg_cmd_all));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      tx_hold      <= 1'b0;
      rx_forward   <= 1'b0;
      rx_drop      <= 1'b0;
      pause_req    <= 1'b0;
      pause_quanta <= QW'(TX_QUANTA_RST);
    end else begin
      cnt_q      <= cnt_d;
      tx_hold    <= hold_d;
      rx_forward <= fwd_d;
      rx_drop    <= drop_d;
      if (pause_trig) begin
        pause_req    <= 1'b1;
        pause_quanta <= cfg_tx_quanta;
      end else if (pause_ack) begin
        pause_req    <= 1'b0;
      end
    end
  end

  assign tx_data_ok = !tx_hold && !pause_req;

  // R4
  fwd_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_forward && rx_drop));

  // R8
  hold_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_hold) |-> !$past(tx_in_frame));

  // R3
  ignore_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_is_pause && cfg_ignore && cnt_q == '0) |=> !tx_hold);

  // R7
  zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_is_pause && !cfg_ignore && ctl_quanta == '0) |=> !tx_hold);

  // R5
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && !ctl_is_pause && ctl_is_cmd && !cfg_cmd_all) |=> (rx_drop && !rx_forward));

  // R9
  req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack) |=> (pause_req && $stable(pause_quanta)) || $past(pause_trig));

  // R10
  req_blocks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> !tx_data_ok);
endmodule

// File: tb/test_pause_flow_ctl.sv
`timescale 1ns/1ps
module test_pause_flow_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ignore = 0, cfg_forward = 0, cfg_cmd_all = 0;
  logic [15:0] cfg_tx_quanta = 16'h0;
  logic ctl_valid = 0, ctl_is_pause = 0, ctl_is_cmd = 0;
  logic [15:0] ctl_quanta = 16'h0;
  logic tx_in_frame = 0, pause_trig = 0, pause_ack = 0;
  logic tx_hold, tx_data_ok, rx_forward, rx_drop, pause_req;
  logic [15:0] pause_quanta;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  pause_flow_ctl i_pause_flow_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_ignore(cfg_ignore), .cfg_forward(cfg_forward),
    .cfg_cmd_all(cfg_cmd_all), .cfg_tx_quanta(cfg_tx_quanta), .ctl_valid(ctl_valid),
    .ctl_is_pause(ctl_is_pause), .ctl_is_cmd(ctl_is_cmd), .ctl_quanta(ctl_quanta),
    .tx_in_frame(tx_in_frame), .tx_hold(tx_hold), .tx_data_ok(tx_data_ok),
    .rx_forward(rx_forward), .rx_drop(rx_drop), .pause_trig(pause_trig),
    .pause_req(pause_req), .pause_quanta(pause_quanta), .pause_ack(pause_ack));

  // [7]ignore [6]forward [5]cmd_all [4]is_pause [3]is_cmd [2]exp_fwd [1]exp_drop [0]exp_hold
  localparam logic [7:0] VEC [8] = '{
    8'b0001_0011, 8'b0101_0101, 8'b1001_0010, 8'b1101_0100,
    8'b0000_1010, 8'b0010_1100, 8'b0110_0000, 8'b0011_1011 };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic p, logic c, logic [15:0] q);
    @(negedge clk);
    ctl_valid = 1; ctl_is_pause = p; ctl_is_cmd = c; ctl_quanta = q;
    @(negedge clk);
    ctl_valid = 0; ctl_is_pause = 0; ctl_is_cmd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (tx_hold && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_hold", tx_hold, 0);
    chk("R1 pause_req", pause_req, 0);
    chk("R1 fwd/drop", {rx_forward, rx_drop}, 0);
    chk("R1 tx_data_ok", tx_data_ok, 1);
    chk("R1 pause_quanta", pause_quanta, 16'hF000);

    // R3 R4 R5 R11 table of decision vectors, quanta 1
    for (int i = 0; i < 8; i++) begin
      cfg_ignore = VEC[i][7]; cfg_forward = VEC[i][6]; cfg_cmd_all = VEC[i][5];
      send(VEC[i][4], VEC[i][3], 16'd1);
      chk($sformatf("R4/R5/R11 fwd vec%0d", i), rx_forward, VEC[i][2]);
      chk($sformatf("R4/R5/R11 drop vec%0d", i), rx_drop, VEC[i][1]);
      chk($sformatf("R2/R3 hold vec%0d", i), tx_hold, VEC[i][0]);
      idle(12);
      chk($sformatf("R4 pulse vec%0d", i), rx_forward | rx_drop, 0);
    end
    cfg_ignore = 0; cfg_forward = 0; cfg_cmd_all = 0;

    // R2 exact hold length, R10 data blocked
    send(1, 0, 16'd2);
    chk("R10 data_ok during hold", tx_data_ok, 0);
    hold_len(n);
    chk("R2 hold cycles q=2", n, 16);
    chk("R10 data_ok after hold", tx_data_ok, 1);
    send(1, 0, 16'd5);
    hold_len(n);
    chk("R2 hold cycles q=5", n, 40);

    // R6 reload
    send(1, 0, 16'd4);
    idle(9);
    send(1, 0, 16'd1);
    hold_len(n);
    chk("R6 reload hold cycles", n, 8);

    // R7 zero quanta
    send(1, 0, 16'd4);
    idle(3);
    send(1, 0, 16'd0);
    chk("R7 zero quanta release", tx_hold, 0);

    // R8 frame boundary
    idle(2);
    tx_in_frame = 1;
    send(1, 0, 16'd3);
    idle(3);
    chk("R8 no hold mid-frame", tx_hold, 0);
    tx_in_frame = 0;
    @(negedge clk);
    chk("R8 hold at boundary", tx_hold, 1);
    idle(30);
    chk("R8 hold expired", tx_hold, 0);

    // R9 R10 pause request
    cfg_tx_quanta = 16'h1234;
    @(negedge clk); pause_trig = 1;
    @(negedge clk); pause_trig = 0;
    chk("R9 req set", pause_req, 1);
    chk("R9 quanta captured", pause_quanta, 16'h1234);
    chk("R10 data blocked by req", tx_data_ok, 0);
    cfg_tx_quanta = 16'h00AA;
    idle(5);
    chk("R9 req held", pause_req, 1);
    chk("R9 quanta stable", pause_quanta, 16'h1234);
    pause_ack = 1;
    @(negedge clk); pause_ack = 0;
    chk("R9 req cleared", pause_req, 0);
    chk("R10 data ok after ack", tx_data_ok, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule